// File: doc/BRIEF.md
# Three-Phase Polyphase Interpolating FIR

The block raises the sample rate of a signed stream by three. It behaves as a 55-tap prototype low-pass filter applied to the input after two zeros have been inserted between samples. It never multiplies by those inserted zeros. The taps are split into three interleaved subsets, one per output phase. Each output is then a 19-term dot product of the newest 19 input samples with the subset for that phase.

The datapath has 19 multiplier slots. Each slot holds three fixed constants, one for each phase, and the current phase index picks which constant the slot applies. The slots are summed at full precision, the sum is rounded to nearest, and the result is saturated to the output width. The coefficients are a parameter vector; designing them is the user's job.

A three-state machine orders the work. `ST_LOAD` (phase 0, input ready) waits for `in_valid`. An accepted sample shifts the delay line, emits the phase-0 result and takes the transition LOAD→PH1. `ST_PH1` emits phase 1 and takes PH1→PH2. `ST_PH2` emits phase 2 and takes PH2→LOAD. With no valid input, the machine holds in `ST_LOAD` (LOAD→LOAD).

Top module: `interp3_fir`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and every delay-line entry is zero, so the first outputs contain only contributions from samples accepted since reset.
- R2: `in_ready` is 1 only in the phase-0 state. After a sample is accepted, `in_ready` is 0 for exactly the next two cycles and then returns to 1.
- R3: Each accepted sample yields exactly three outputs, on three consecutive cycles. The first appears in the cycle after acceptance, and `out_phase` reads 0, 1, 2 in that order.
- R4: For the m-th accepted sample x[m], the output of phase p is the sum over k = 0..18 of h[3k+p]·x[m-k]. Any index of h at 55 or above counts as zero, and so does any sample from before reset. This equals a direct convolution of h with the input stream zero-stuffed by three.
- R5: Coefficient h[n] is the signed `CW`-bit field `COEFS[n*CW +: CW]`.
- R6: The delay line shifts only when `in_valid` and `in_ready` are both 1. `in_data` presented while no transfer occurs has no effect on any output.
- R7: The full-precision sum s is rounded as (s + 2^(SHIFT-1)) >> SHIFT, an arithmetic shift (half rounds up). `SHIFT` defaults to `CW-1`.
- R8: A rounded result above 2^(OW-1)-1 or below -2^(OW-1) is clamped to that bound.
- R9: With `in_valid` held at 1, the block accepts one sample every three cycles and `out_valid` stays 1 on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample (phase-0 state) |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Output sample present |
| out_phase | output | 2 | Phase of the output sample: 0, 1 or 2 |
| out_data | output | OW | Signed rounded, saturated output |

## Verification
On every cycle, the assertions check the handshake and sequencing rules. These are: an accepted sample is followed by phases 0, 1 and 2 on consecutive cycles, `in_ready` is low while phases 1 and 2 are pending, and the block is ready whenever it is not emitting. Only the bench scenarios can show that the arithmetic is correct. The bench compares every output against a zero-stuffed convolution model under several kinds of input:
- an impulse, which exposes each coefficient and its placement;
- full-scale positive and negative steps, which drive the sum into saturation;
- random data with idle gaps carrying junk input data;
- a back-to-back stream.

// File: rtl/interp3_pkg.sv
package interp3_pkg;

    localparam int PHASES   = 3;
    localparam int PH_W     = 2;
    localparam int DEF_NTAP = 55;
    localparam int DEF_CW   = 16;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_PH1  = 2'd1,
        ST_PH2  = 2'd2
    } ctrl_state_t;

    // Symmetric triangular default prototype, peak 28*32.
    function automatic logic [DEF_NTAP*DEF_CW-1:0] default_coefs();
        logic [DEF_NTAP*DEF_CW-1:0] r;
        int v;
        r = '0;
        for (int n = 0; n < DEF_NTAP; n++) begin
            v = (n < (DEF_NTAP + 1) / 2) ? (n + 1) : (DEF_NTAP - n);
            r[n*DEF_CW +: DEF_CW] = DEF_CW'(v * 32);
        end
        return r;
    endfunction

endpackage

// File: rtl/interp3_ctrl.sv
module interp3_ctrl
    import interp3_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    output logic            shift,
    output logic            emit,
    output logic [PH_W-1:0] phase
);

    ctrl_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: if (in_valid) state_d = ST_PH1;
            ST_PH1:  state_d = ST_PH2;
            ST_PH2:  state_d = ST_LOAD;
            default: state_d = ST_LOAD;
        endcase
    end

    always_comb begin
        in_ready = 1'b0;
        shift    = 1'b0;
        emit     = 1'b0;
        phase    = '0;
        unique case (state_q)
            ST_LOAD: begin
                in_ready = 1'b1;
                shift    = in_valid;
                emit     = in_valid;
                phase    = PH_W'(0);
            end
            ST_PH1: begin
                emit  = 1'b1;
                phase = PH_W'(1);
            end
            ST_PH2: begin
                emit  = 1'b1;
                phase = PH_W'(2);
            end
            default: begin
                phase = '0;
            end
        endcase
    end

endmodule

// File: rtl/interp3_tapline.sv
module interp3_tapline #(
    parameter int DW   = 16,
    parameter int LEN  = 19
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift,
    input  logic [DW-1:0]           din,
    output logic [LEN-1:0][DW-1:0]  line
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     line <= '0;
        else if (shift) line <= {line[LEN-2:0], din};
    end

endmodule

// File: rtl/interp3_rcm.sv
module interp3_rcm #(
    parameter int DW = 16,
    parameter int CW = 16,
    parameter logic signed [CW-1:0] K0 = '0,
    parameter logic signed [CW-1:0] K1 = '0,
    parameter logic signed [CW-1:0] K2 = '0
) (
    input  logic [1:0]                 phase,
    input  logic signed [DW-1:0]       x,
    output logic signed [DW+CW-1:0]    prod
);

    localparam int PW = DW + CW;

    logic signed [CW-1:0] k_sel;

    always_comb begin
        unique case (phase)
            2'd0:    k_sel = K0;
            2'd1:    k_sel = K1;
            default: k_sel = K2;
        endcase
    end

    assign prod = PW'(x) * PW'(k_sel);

endmodule

// File: rtl/interp3_accum.sv
module interp3_accum #(
    parameter int PW    = 32,
    parameter int NSUB  = 19,
    parameter int OW    = 16,
    parameter int SHIFT = 15
) (
    input  logic [NSUB-1:0][PW-1:0]  prods,
    output logic signed [OW-1:0]     result
);

    localparam int AW = PW + $clog2(NSUB) + 1;
    localparam logic signed [AW-1:0] HALF = AW'(1) << (SHIFT - 1);
    localparam logic signed [AW-1:0] MAXV = (AW'(1) << (OW - 1)) - AW'(1);
    localparam logic signed [AW-1:0] MINV = -(AW'(1) << (OW - 1));

    logic signed [AW-1:0] sum;
    logic signed [AW-1:0] rnd;

    always_comb begin
        sum = '0;
        for (int i = 0; i < NSUB; i++) begin
            sum = sum + AW'($signed(prods[i]));
        end
        rnd = (sum + HALF) >>> SHIFT;
        if (rnd > MAXV)      result = MAXV[OW-1:0];
        else if (rnd < MINV) result = MINV[OW-1:0];
        else                 result = rnd[OW-1:0];
    end

endmodule

// File: rtl/interp3_fir.sv
module interp3_fir
    import interp3_pkg::*;
#(
    parameter int DW    = 16,
    parameter int CW    = DEF_CW,
    parameter int OW    = 16,
    parameter int NTAP  = DEF_NTAP,
    parameter int SHIFT = CW - 1,
    parameter logic [NTAP*CW-1:0] COEFS = default_coefs()
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic signed [DW-1:0]  in_data,
    output logic                  out_valid,
    output logic [1:0]            out_phase,
    output logic signed [OW-1:0]  out_data
);

    localparam int NSUB = (NTAP + PHASES - 1) / PHASES;
    localparam int PW   = DW + CW;
    localparam logic [NSUB*PHASES*CW-1:0] PADDED = (NSUB*PHASES*CW)'(COEFS);

    logic                      shift, emit;
    logic [PH_W-1:0]           phase;
    logic [NSUB-1:0][DW-1:0]   line;
    logic [NSUB-1:0][PW-1:0]   prods;
    logic signed [OW-1:0]      result;

    interp3_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .shift    (shift),
        .emit     (emit),
        .phase    (phase)
    );

    interp3_tapline #(.DW(DW), .LEN(NSUB)) u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (shift),
        .din   (in_data),
        .line  (line)
    );

    // Phase 0 works on the sample being accepted, so the taps look one
    // slot ahead of the stored line; phases 1 and 2 use the stored line.
    for (genvar k = 0; k < NSUB; k++) begin : g_slot
        logic signed [DW-1:0] tap;
        logic signed [PW-1:0] p;
        if (k == 0) begin : g_head
            assign tap = (phase == '0) ? in_data : $signed(line[0]);
        end else begin : g_body
            assign tap = (phase == '0) ? $signed(line[k-1]) : $signed(line[k]);
        end
        interp3_rcm #(
            .DW (DW),
            .CW (CW),
            .K0 (PADDED[(PHASES*k + 0)*CW +: CW]),
            .K1 (PADDED[(PHASES*k + 1)*CW +: CW]),
            .K2 (PADDED[(PHASES*k + 2)*CW +: CW])
        ) u_rcm (
            .phase (phase),
            .x     (tap),
            .prod  (p)
        );
        assign prods[k] = p;
    end

    interp3_accum #(.PW(PW), .NSUB(NSUB), .OW(OW), .SHIFT(SHIFT)) u_acc (
        .prods  (prods),
        .result (result)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_phase <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_phase <= phase;
                out_data  <= result;
            end
        end
    end

endmodule

// File: rtl/interp3_fir_chk.sv
module interp3_fir_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic [1:0] out_phase
);

    AST_ACCEPT_GIVES_PH0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_phase == 2'd0)); // R3

    AST_PH0_THEN_PH1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_phase == 2'd0) |=> (out_valid && out_phase == 2'd1)); // R3

    AST_PH1_THEN_PH2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_phase == 2'd1) |=> (out_valid && out_phase == 2'd2)); // R3

    AST_NO_PHASE3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_phase != 2'd3)); // R3

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R2

    AST_BUSY_DURING_PH1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_phase == 2'd1) |-> !in_ready); // R2

    AST_READY_AFTER_PH2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_phase == 2'd2) |-> in_ready); // R2

    AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R2

    AST_STREAM_CONT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_phase == 2'd2 && in_valid) |=> out_valid); // R9

endmodule

bind interp3_fir interp3_fir_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_phase (out_phase)
);

// File: tb/interp3_fir_tb.sv
module interp3_fir_tb;

    localparam int NT = 55;
    localparam int CWB = 16;

    function automatic logic [NT*CWB-1:0] mk_coefs();
        logic [NT*CWB-1:0] r;
        logic [31:0] s;
        int v;
        s = 32'h1;
        r = '0;
        for (int n = 0; n < NT; n++) begin
            s = s * 32'd1103515245 + 32'd12345;
            v = int'(s[28:16]) - 4096;
            if (n == 0 || n == 3) v = 30000;
            r[n*CWB +: CWB] = CWB'(v);
        end
        return r;
    endfunction

    localparam logic [NT*CWB-1:0] TB_COEFS = mk_coefs();

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [15:0] in_data = '0;
    logic out_valid;
    logic [1:0] out_phase;
    logic signed [15:0] out_data;

    always #10 clk = ~clk;

    interp3_fir #(.DW(16), .CW(CWB), .OW(16), .NTAP(NT), .SHIFT(15), .COEFS(TB_COEFS)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_phase(out_phase), .out_data(out_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    int hist [0:1023];
    int m = 0;
    int exp_d [$];
    int exp_p [$];
    string tag = "R1";
    bit done = 1'b0;

    function automatic int coef(int j);
        return int'($signed(TB_COEFS[j*CWB +: CWB]));
    endfunction

    // Zero-stuffed direct-form convolution (R4, R5, R7, R8).
    function automatic int ref_y(int mm, int p);
        longint acc;
        int n;
        int idx;
        acc = 0;
        n = 3 * mm + p;
        for (int j = 0; j < NT; j++) begin
            idx = n - j;
            if (idx >= 0 && idx % 3 == 0) acc += longint'(coef(j)) * longint'(hist[idx / 3]);
        end
        acc = (acc + 64'sd16384) >>> 15;
        if (acc > 32767) acc = 32767;
        if (acc < -32768) acc = -32768;
        return int'(acc);
    endfunction

    task automatic check(input string t, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (exp_d.size() == 0) begin
                check({tag, " R3 R6 unexpected output"}, 1, 0);
            end else begin
                check({tag, " R4 data"}, int'(out_data), exp_d.pop_front());
                check("R3 phase order", int'(out_phase), exp_p.pop_front());
            end
        end
    end

    task automatic send(input int x, input bit hold);
        in_valid = 1'b1;
        in_data = 16'(x);
        while (!in_ready) @(negedge clk);
        hist[m] = x;
        for (int p = 0; p < 3; p++) begin
            exp_d.push_back(ref_y(m, p));
            exp_p.push_back(p);
        end
        m++;
        @(negedge clk);
        check("R2 ready low after accept", int'(in_ready), 0);
        if (!hold) begin
            in_valid = 1'b0;
            in_data = 16'($urandom);
        end
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            in_data = 16'($urandom);
            @(negedge clk);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 out_valid after reset", int'(out_valid), 0);
        check("R1 in_ready after reset", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        tag = "R1 R5 impulse";
        send(32767, 1'b0);
        for (int i = 0; i < 22; i++) send(0, 1'b0);

        tag = "R8 pos step";
        for (int i = 0; i < 25; i++) send(32767, 1'b1);
        tag = "R8 neg step";
        for (int i = 0; i < 25; i++) send(-32768, 1'b1);

        tag = "R6 R7 random with gaps";
        for (int i = 0; i < 150; i++) begin
            send(int'($signed(16'($urandom))) >>> ($urandom % 4), 1'b0);
            if ($urandom % 4 == 0) idle(1 + $urandom % 5);
        end

        tag = "R9 back-to-back";
        for (int i = 0; i < 60; i++) send(int'($signed(16'($urandom))), 1'b1);
        in_valid = 1'b0;
        idle(6);
        check("R9 queue drained", exp_d.size(), 0);
        check("R2 ready when idle", int'(in_ready), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R3 actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule